// File: doc/BRIEF.md
# Halfword multiply-accumulate execute unit

This unit decodes and executes one family of 32-bit DSP instruction words. Each word picks one 16-bit half of each of two 32-bit source values and multiplies them. The product may be doubled, and is then added to or subtracted from a 64-bit accumulator. The accumulator is the old contents of an even/odd register pair, and that same pair is the destination.

One decoded datapath covers all 32 variants. A variant is fixed by five bits: the signedness, the direction (add or subtract), the doubling, and the half taken from each source. The caller reads the two source registers and the destination pair and presents their values together with the word. One cycle later the unit returns the new pair value and the destination index. It also returns a flag that says whether the word belongs to this class. The result has no saturation and no overflow indication.

Top module: `hmac_unit`

## Requirements
- R1: `out_match` is 1 for a word only when bits 31:28 are 1110, bits 27:24 are 0110 and bit 7 is 0 (so 0xE695DF10 matches). For any other word it is 0.
- R2: `out_dest` carries bits 4:0 of the word that was accepted. These bits are the index of the destination pair. The first source register is named by bits 20:16 and the second by bits 12:8.
- R3: Bit 6 selects the half of `src_a` (1 = bits 31:16, 0 = bits 15:0). Bit 5 selects the half of `src_b` in the same way.
- R4: Bit 22 = 1 zero-extends both selected halves, which gives an unsigned product. Bit 22 = 0 sign-extends them. The 32-bit product is extended to 64 bits in the same manner.
- R5: Bit 23 = 1 doubles the product, and the doubling is exact in 64 bits. For example, signed 0x8000 × 0x8000 doubled gives +0x80000000, and unsigned 0xFFFF × 0xFFFF doubled gives 0x1FFFC0002.
- R6: Bit 21 = 1 gives `acc_in` minus the product. Bit 21 = 0 gives `acc_in` plus the product.
- R7: The add and the subtract wrap modulo 2^64. There is no saturation.
- R8: For a word that does not match, `out_acc` equals the `acc_in` that was presented with it, unchanged.
- R9: `out_valid` goes to 1 at the first clock edge after an edge at which `in_valid` was 1. The synchronous active-high `rst` clears `out_valid`.
- R10: While `in_valid` is 0, `out_acc`, `out_dest` and `out_match` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word and operands are present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Value of the first source register |
| src_b | input | 32 | Value of the second source register |
| acc_in | input | 64 | Old value of the destination pair |
| out_valid | output | 1 | Result registered from an accepted word |
| out_match | output | 1 | Word belongs to this instruction class |
| out_dest | output | 5 | Destination pair index |
| out_acc | output | 64 | New value of the destination pair |

## Verification
The bench builds the unit with its default widths: 32-bit sources, 16-bit halves and a 64-bit accumulator. These widths make every one of the 32 mode and half-select combinations reachable, and a reference model checks each of them under several operand sets. They also make the extreme cases reachable. Signed 0x8000 × 0x8000 doubled must come out positive. Unsigned 0xFFFF × 0xFFFF doubled carries past bit 31. An accumulator at all ones wraps through zero. The bench also covers words with bit 7 set or a wrong class nibble, and checks that they pass the accumulator through untouched.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
  localparam int INSN_W = 32;
  localparam int IDX_W  = 5;
  // bit positions that the decoder relies on
  localparam int B_DBL  = 23;
  localparam int B_UNS  = 22;
  localparam int B_SUB  = 21;
  localparam int B_AHI  = 6;
  localparam int B_BHI  = 5;
  localparam int B_ZERO = 7;
  localparam logic [7:0] CLASS_CODE = 8'hE6;

  typedef struct packed {
    logic             hit;
    logic             dbl;
    logic             uns;
    logic             sub;
    logic             a_hi;
    logic             b_hi;
    logic [IDX_W-1:0] dst;
  } op_t;
endpackage

// File: rtl/hmac_decode.sv
module hmac_decode
  import hmac_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output op_t               op
);
  logic unused_fields;
  assign unused_fields = ^{instr[20:8]};

  always_comb begin
    op.hit  = (instr[31:24] == CLASS_CODE) && !instr[B_ZERO];
    op.dbl  = instr[B_DBL];
    op.uns  = instr[B_UNS];
    op.sub  = instr[B_SUB];
    op.a_hi = instr[B_AHI];
    op.b_hi = instr[B_BHI];
    op.dst  = instr[IDX_W-1:0];
  end
endmodule

// File: rtl/hmac_operand.sv
module hmac_operand #(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic                     uns,
  input  logic [1:0]               sel_hi,
  input  logic [2*DATA_W-1:0]      words,
  output logic signed [2*HALF_W+1:0] ext_pair
);
  // one extender per source, chosen by generate
  for (genvar g = 0; g < 2; g++) begin : g_src
    logic [DATA_W-1:0] w;
    logic [HALF_W-1:0] half;
    assign w    = words[g*DATA_W +: DATA_W];
    assign half = sel_hi[g] ? w[DATA_W-1:HALF_W] : w[HALF_W-1:0];
    assign ext_pair[g*(HALF_W+1) +: HALF_W+1] = {(uns ? 1'b0 : half[HALF_W-1]), half};
  end
endmodule

// File: rtl/hmac_product.sv
module hmac_product #(
  parameter int HALF_W = 16,
  parameter int ACC_W  = 64,
  localparam int OP_W  = HALF_W + 1,
  localparam int PR_W  = 2 * OP_W
) (
  input  logic signed [OP_W-1:0] a_ext,
  input  logic signed [OP_W-1:0] b_ext,
  input  logic                   dbl,
  output logic [ACC_W-1:0]       prod
);
  logic signed [PR_W-1:0] p;
  logic [ACC_W-1:0]       p_wide;

  assign p      = a_ext * b_ext;
  assign p_wide = {{(ACC_W-PR_W){p[PR_W-1]}}, p};
  assign prod   = dbl ? {p_wide[ACC_W-2:0], 1'b0} : p_wide;
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
  import hmac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 64,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [ACC_W-1:0]  acc_in,
  output logic              out_valid,
  output logic              out_match,
  output logic [4:0]        out_dest,
  output logic [ACC_W-1:0]  out_acc
);
  op_t                      op;
  logic signed [2*HALF_W+1:0] ext_pair;
  logic [ACC_W-1:0]         prod;
  logic [ACC_W-1:0]         next_acc;

  hmac_decode u_dec (.instr(instr), .op(op));

  hmac_operand #(.DATA_W(DATA_W)) u_opnd (
    .uns(op.uns), .sel_hi({op.b_hi, op.a_hi}),
    .words({src_b, src_a}), .ext_pair(ext_pair)
  );

  hmac_product #(.HALF_W(HALF_W), .ACC_W(ACC_W)) u_mul (
    .a_ext(ext_pair[HALF_W:0]), .b_ext(ext_pair[2*HALF_W+1:HALF_W+1]),
    .dbl(op.dbl), .prod(prod)
  );

  always_comb begin
    if (!op.hit)     next_acc = acc_in;
    else if (op.sub) next_acc = acc_in - prod;
    else             next_acc = acc_in + prod;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_match <= 1'b0;
      out_dest  <= '0;
      out_acc   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_match <= op.hit;
        out_dest  <= op.dst;
        out_acc   <= next_acc;
      end
    end
  end
endmodule

// File: rtl/hmac_unit_chk.sv
module hmac_unit_chk #(
  parameter int ACC_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [31:0]      instr,
  input logic [ACC_W-1:0] acc_in,
  input logic             out_valid,
  input logic             out_match,
  input logic [4:0]       out_dest,
  input logic [ACC_W-1:0] out_acc
);
  logic unused_chk;
  assign unused_chk = ^{instr[23:8], instr[6:5]};

  logic is_class;
  assign is_class = (instr[31:24] == 8'hE6) && !instr[7];

  p_match_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_class) |=> out_match);
  p_nomatch_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_class) |=> !out_match);
  p_dest_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_dest == $past(instr[4:0]));
  p_passthru_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_class) |=> out_acc == $past(acc_in));
  p_valid_on_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_off_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_acc) && $stable(out_dest) && $stable(out_match)));
endmodule

bind hmac_unit hmac_unit_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .acc_in(acc_in),
  .out_valid(out_valid), .out_match(out_match), .out_dest(out_dest), .out_acc(out_acc)
);

// File: tb/tb_hmac_unit.sv
module tb_hmac_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [63:0] acc_in = '0;
  logic        out_valid, out_match;
  logic [4:0]  out_dest;
  logic [63:0] out_acc;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  hmac_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .out_valid(out_valid), .out_match(out_match), .out_dest(out_dest), .out_acc(out_acc)
  );

  always #5 clk = ~clk;

  // small register file model: 32 words, pairs are even/odd
  logic [31:0] rf [32];

  localparam int NV = 8;
  localparam logic [31:0] V_INS [NV] = '{32'hE695DF10, 32'hE6B5DF10, 32'hE6D5DF10, 32'hE695DF70,
                                         32'hE675DF10, 32'hE615DF40, 32'hE695DF90, 32'hE795DF10};
  localparam logic [31:0] V_A   [NV] = '{32'h3, 32'h3, 32'h3, 32'h8000_0000,
                                         32'hFFFF, 32'h0001_0000, 32'h5, 32'h5};
  localparam logic [31:0] V_B   [NV] = '{32'hFFFE, 32'hFFFE, 32'hFFFE, 32'h8000_0000,
                                         32'hFFFF, 32'h1, 32'h5, 32'h5};
  localparam logic [63:0] V_ACC [NV] = '{64'd100, 64'd100, 64'd0, 64'd0,
                                         64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, 64'h1234};
  localparam logic        V_M   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [63:0] V_EXP [NV] = '{64'h58, 64'h70, 64'h5FFF4, 64'h8000_0000,
                                         64'hFFFF_FFFF_0001_FFFF, 64'h0, 64'h1234, 64'h1234};
  localparam string V_REQ [NV] = '{"R5 signed dbl add", "R6 subtract", "R4 unsigned",
                                   "R5 0x8000 squared dbl", "R4/R6 unsigned sub",
                                   "R7 wrap / R3 hi-lo", "R8 bit7 set", "R1/R8 wrong class"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_acc(input logic [31:0] ins, input logic [31:0] a,
                                          input logic [31:0] b, input logic [63:0] acc);
    logic [15:0] ha, hb;
    longint ea, eb, p;
    ha = ins[6] ? a[31:16] : a[15:0];
    hb = ins[5] ? b[31:16] : b[15:0];
    ea = ins[22] ? longint'({48'b0, ha}) : longint'($signed(ha));
    eb = ins[22] ? longint'({48'b0, hb}) : longint'($signed(hb));
    p  = ea * eb;
    if (ins[23]) p = p * 2;
    return ins[21] ? acc - 64'(p) : acc + 64'(p);
  endfunction

  task automatic issue(input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic [63:0] acc);
    @(negedge clk);
    in_valid = 1'b1; instr = ins; src_a = a; src_b = b; acc_in = acc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 50000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset clears valid", {63'b0, out_valid}, 64'h0);
    rst = 1'b0;

    // table of directed vectors
    for (int i = 0; i < NV; i++) begin
      issue(V_INS[i], V_A[i], V_B[i], V_ACC[i]);
      check({V_REQ[i], " acc"}, out_acc, V_EXP[i]);
      check("R1 match", {63'b0, out_match}, {63'b0, V_M[i]});
      check("R2 dest", {59'b0, out_dest}, {59'b0, V_INS[i][4:0]});
      check("R9 valid", {63'b0, out_valid}, 64'h1);
    end

    // every mode/select combination through the register model
    for (int s = 0; s < 3; s++) begin
      for (int v = 0; v < 32; v++) begin
        logic [31:0] ins;
        logic [63:0] old_pair;
        logic [4:0] d;
        rf[21] = (s == 0) ? 32'h8000_7FFF : (s == 1) ? 32'hFFFF_0001 : 32'h1234_ABCD;
        rf[31] = (s == 0) ? 32'h7FFF_8000 : (s == 1) ? 32'h8000_FFFF : 32'hF00D_0F0F;
        rf[16] = 32'hDEAD_0000 + 32'(v);
        rf[17] = (s == 1) ? 32'hFFFF_FFFF : 32'h0000_0001;
        ins = {8'hE6, v[4], v[3], v[2], 5'd21, 3'b110, 5'd31, 1'b0, v[1], v[0], 5'd16};
        d = ins[4:0];
        old_pair = {rf[d + 5'd1], rf[d]};
        issue(ins, rf[ins[20:16]], rf[ins[12:8]], old_pair);
        check("R3/R4/R5/R6/R7 model", out_acc, ref_acc(ins, rf[21], rf[31], old_pair));
        {rf[d + 5'd1], rf[d]} = out_acc;
      end
    end

    // R10: idle cycles with changing inputs leave outputs alone
    issue(32'hE695DF10, 32'h3, 32'hFFFE, 64'd100);
    instr = 32'hE6D5DF62; acc_in = 64'h5555; src_a = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R10 hold acc", out_acc, 64'h58);
    check("R10 hold dest", {59'b0, out_dest}, 64'd16);
    check("R9 valid drops", {63'b0, out_valid}, 64'h0);

    // R9: reset while a word is presented
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R9 reset overrides valid", {63'b0, out_valid}, 64'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    finish_run();
  end
endmodule